// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache with Hint Commands

This block is a small two-way set-associative write-back data cache sitting between one processor-side command port and a word-addressed main memory. Besides ordinary loads and stores it executes five hint commands:

- prefetch a line;
- install a zeroed line without reading memory;
- drop a line without writing it back;
- push a line out to memory;
- load a word and then mark its line as the next victim.

Each command is taken through a valid/ready handshake and answered by a single one-cycle response pulse, whether or not it returns data. Only one command is in flight at a time, and only one memory word transfer is outstanding.

The geometry is 16 sets of 2 ways, with 4 words of 32 bits per line and 32-bit byte addresses. Each set keeps one bit naming its least recently used way.

A single sequencer runs five states:

- `ST_IDLE` raises `req_ready` and moves to `ST_LOOKUP` on `req_valid`.
- `ST_LOOKUP` inspects both ways and takes one of three exits. It goes to `ST_RESP` when the command completes. It goes to `ST_WBACK` when a dirty line must leave first. It goes to `ST_FILL` when a missing line must be read.
- `ST_WBACK` writes four words and then invalidates the way. It returns to `ST_LOOKUP`.
- `ST_FILL` reads four words and installs the line clean. It returns to `ST_LOOKUP`.
- `ST_RESP` pulses `resp_valid` and returns to `ST_IDLE`.

Because every miss ends back in `ST_LOOKUP`, the retried lookup hits and the command completes as a hit.

Top module: `hint_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` and `mem_req` are 0. Every line is invalid.
- R2: Opcode 0 (load) returns the latest stored word of the byte address. Opcode 1 (store) writes `req_wdata` to that word and marks the line dirty. A hit causes no memory traffic.
- R3: A miss whose victim is invalid or clean issues exactly 4 memory reads, for word offsets 0, 1, 2, 3 in that order, and no writes.
- R4: A miss whose victim is valid and dirty first writes the victim's 4 words back and only then issues the 4 reads.
- R5: The victim is way 0 if invalid, else way 1 if invalid, else the least recently used way. A hit by load, store, prefetch or allocate-zero makes the other way the least recently used one. Both ways never hold the same tag.
- R6: Opcode 2 (prefetch) fills an absent line like a load miss. It returns zero data. On a present line it causes no memory traffic.
- R7: Opcode 3 (allocate-zero) makes all 4 words of the line read as zero and marks it valid and dirty. It never reads memory, though a dirty victim is still written back.
- R8: Opcode 4 (discard) invalidates a present line with no write-back, even when the line is dirty. Later loads see the memory contents. On an absent line it does nothing.
- R9: Opcode 5 (evict) removes a present line, writing its 4 words back only if the line is dirty. On an absent line it causes no traffic.
- R10: Opcode 6 (load-last) returns the word like a load, filling on a miss. It then makes its own way the least recently used, so the next miss in that set replaces it.
- R11: Every command, including opcode 7 (no operation, no effect, no traffic), gets exactly one one-cycle `resp_valid` pulse. `resp_rdata` is zero for non-load opcodes. `req_ready` is high only while idle, and the block is then quiet on both ports.
- R12: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until `mem_ack`. `mem_addr` is a word address: tag, set index and word offset from high to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Command accepted on this edge when both high |
| req_op | input | 3 | Command opcode (see R2, R6 to R11) |
| req_addr | input | 32 | Byte address of the target word |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Load data, zero for other commands |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Transfer done; read data valid |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The assertions assume that memory raises `mem_ack` only while `mem_req` is high, and holds it for one cycle per word. They also assume that `req_op` and the address stay unchanged while `req_valid` waits for `req_ready`. The bench memory answers each request one cycle after it appears and drops the acknowledge on the following edge. The bench driver holds a command until the idle-state handshake takes it and offers nothing else until the response pulse has been seen. Addresses are confined to four tags over a few sets, so conflicts, dirty victims and both replacement exits happen often.

// File: rtl/hc_pkg.sv
package hc_pkg;

    typedef enum logic [2:0] {
        OP_LOAD     = 3'd0,
        OP_STORE    = 3'd1,
        OP_PREFETCH = 3'd2,
        OP_ZERO     = 3'd3,
        OP_DISCARD  = 3'd4,
        OP_EVICT    = 3'd5,
        OP_LOADLAST = 3'd6,
        OP_NONE     = 3'd7
    } hc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WBACK,
        ST_FILL,
        ST_RESP
    } hc_state_e;

endpackage

// File: rtl/hc_tag_array.sv
module hc_tag_array #(
    parameter int SETS  = 16,
    parameter int TAG_W = 24,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] cmp_tag,
    input  logic             sel_way,
    output logic [TAG_W-1:0] sel_tag,
    output logic             hit,
    output logic             hit_way,
    output logic             hit_dirty,
    output logic             vic_way,
    output logic             vic_dirty,
    input  logic             inst_en,
    input  logic             inst_way,
    input  logic             inst_dirty,
    input  logic             inv_en,
    input  logic             inv_way,
    input  logic             dirty_en,
    input  logic             dirty_way,
    input  logic             lru_en,
    input  logic             lru_way
);
    localparam int WAYS = 2;

    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic             lru_q   [SETS];
    logic [WAYS-1:0]  way_hit;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = valid_q[idx][w] && (tag_q[idx][w] == cmp_tag);
    end

    assign hit       = |way_hit;
    assign hit_way   = way_hit[1];
    assign hit_dirty = dirty_q[idx][hit_way];
    assign sel_tag   = tag_q[idx][sel_way];

    always_comb begin
        if (!valid_q[idx][0])      vic_way = 1'b0;
        else if (!valid_q[idx][1]) vic_way = 1'b1;
        else                       vic_way = lru_q[idx];
    end
    assign vic_dirty = valid_q[idx][vic_way] && dirty_q[idx][vic_way];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                lru_q[s]   <= 1'b0;
            end
        end else begin
            if (inv_en) begin
                valid_q[idx][inv_way] <= 1'b0;
                dirty_q[idx][inv_way] <= 1'b0;
            end
            if (inst_en) begin
                valid_q[idx][inst_way] <= 1'b1;
                dirty_q[idx][inst_way] <= inst_dirty;
            end
            if (dirty_en) dirty_q[idx][dirty_way] <= 1'b1;
            if (lru_en)   lru_q[idx] <= lru_way;
        end
    end

    always_ff @(posedge clk) begin
        if (inst_en) tag_q[idx][inst_way] <= cmp_tag;
    end

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(way_hit[0] && way_hit[1])); // R5

endmodule

// File: rtl/hc_data_array.sv
module hc_data_array #(
    parameter int SETS   = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(SETS),
    parameter int WORD_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              rd_way,
    input  logic [WORD_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              zero_en,
    input  logic              zero_way
);
    localparam int WAYS = 2;

    logic [DATA_W-1:0] line_q [SETS][WAYS][WORDS];

    assign rd_data = line_q[idx][rd_way][rd_word];

    always_ff @(posedge clk) begin
        if (zero_en) begin
            for (int k = 0; k < WORDS; k++) line_q[idx][zero_way][k] <= '0;
        end else if (wr_en) begin
            line_q[idx][wr_way][wr_word] <= wr_data;
        end
    end

endmodule

// File: rtl/hint_cache.sv
module hint_cache
    import hc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 16,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int WORD_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - 2 - WORD_W - IDX_W;
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS - 1);

    hc_state_e         state_q, state_d;
    hc_op_e            op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d;
    logic              way_q, way_d;
    logic [WORD_W-1:0] cnt_q;
    logic              cnt_clr, cnt_inc, miss_go;

    logic [WORD_W-1:0] word_sel;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;

    assign word_sel = addr_q[2 +: WORD_W];
    assign idx      = addr_q[2 + WORD_W +: IDX_W];
    assign tag      = addr_q[ADDR_W-1 -: TAG_W];

    logic [TAG_W-1:0] sel_tag;
    logic hit, hit_way, hit_dirty, vic_way, vic_dirty;
    logic inst_en, inst_way, inst_dirty, inv_en, inv_way;
    logic dirty_en, dirty_way, lru_en, lru_way;
    logic rd_way, dwr_en, dwr_way, zero_en, zero_way;
    logic [WORD_W-1:0] rd_word, dwr_word;
    logic [DATA_W-1:0] rd_data, dwr_data;

    hc_tag_array #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(idx), .cmp_tag(tag),
        .sel_way(way_q), .sel_tag(sel_tag),
        .hit(hit), .hit_way(hit_way), .hit_dirty(hit_dirty),
        .vic_way(vic_way), .vic_dirty(vic_dirty),
        .inst_en(inst_en), .inst_way(inst_way), .inst_dirty(inst_dirty),
        .inv_en(inv_en), .inv_way(inv_way),
        .dirty_en(dirty_en), .dirty_way(dirty_way),
        .lru_en(lru_en), .lru_way(lru_way)
    );

    hc_data_array #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W),
                    .IDX_W(IDX_W), .WORD_W(WORD_W)) u_data (
        .clk(clk), .idx(idx),
        .rd_way(rd_way), .rd_word(rd_word), .rd_data(rd_data),
        .wr_en(dwr_en), .wr_way(dwr_way), .wr_word(dwr_word), .wr_data(dwr_data),
        .zero_en(zero_en), .zero_way(zero_way)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Command, counter and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            way_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                op_q    <= hc_op_e'(req_op);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_LOOKUP) rdata_q <= rdata_d;
            way_q <= way_d;
            if (cnt_clr)      cnt_q <= '0;
            else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign resp_rdata = rdata_q;
    assign mem_wdata  = rd_data;
    assign mem_addr   = (state_q == ST_WBACK) ? {sel_tag, idx, cnt_q} : {tag, idx, cnt_q};

    // Next state and control outputs
    always_comb begin
        state_d    = state_q;
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        inst_en    = 1'b0;
        inst_way   = vic_way;
        inst_dirty = 1'b0;
        inv_en     = 1'b0;
        inv_way    = hit_way;
        dirty_en   = 1'b0;
        dirty_way  = hit_way;
        lru_en     = 1'b0;
        lru_way    = ~hit_way;
        dwr_en     = 1'b0;
        dwr_way    = hit_way;
        dwr_word   = word_sel;
        dwr_data   = wdata_q;
        zero_en    = 1'b0;
        zero_way   = hit_way;
        rd_way     = hit_way;
        rd_word    = word_sel;
        way_d      = way_q;
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        miss_go    = 1'b0;
        rdata_d    = '0;

        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) state_d = ST_LOOKUP;
            end

            ST_LOOKUP: begin
                unique case (op_q)
                    OP_LOAD, OP_LOADLAST: begin
                        if (hit) begin
                            rdata_d = rd_data;
                            lru_en  = 1'b1;
                            lru_way = (op_q == OP_LOADLAST) ? hit_way : ~hit_way;
                            state_d = ST_RESP;
                        end else begin
                            miss_go = 1'b1;
                        end
                    end
                    OP_STORE: begin
                        if (hit) begin
                            dwr_en   = 1'b1;
                            dirty_en = 1'b1;
                            lru_en   = 1'b1;
                            state_d  = ST_RESP;
                        end else begin
                            miss_go = 1'b1;
                        end
                    end
                    OP_PREFETCH: begin
                        if (hit) begin
                            lru_en  = 1'b1;
                            state_d = ST_RESP;
                        end else begin
                            miss_go = 1'b1;
                        end
                    end
                    OP_ZERO: begin
                        if (hit) begin
                            zero_en  = 1'b1;
                            dirty_en = 1'b1;
                            lru_en   = 1'b1;
                            state_d  = ST_RESP;
                        end else if (vic_dirty) begin
                            way_d   = vic_way;
                            cnt_clr = 1'b1;
                            state_d = ST_WBACK;
                        end else begin
                            inst_en    = 1'b1;
                            inst_way   = vic_way;
                            inst_dirty = 1'b1;
                            zero_en    = 1'b1;
                            zero_way   = vic_way;
                            lru_en     = 1'b1;
                            lru_way    = ~vic_way;
                            state_d    = ST_RESP;
                        end
                    end
                    OP_DISCARD: begin
                        inv_en  = hit;
                        state_d = ST_RESP;
                    end
                    OP_EVICT: begin
                        if (hit && hit_dirty) begin
                            way_d   = hit_way;
                            cnt_clr = 1'b1;
                            state_d = ST_WBACK;
                        end else begin
                            inv_en  = hit;
                            state_d = ST_RESP;
                        end
                    end
                    OP_NONE: state_d = ST_RESP;
                endcase
                if (miss_go) begin
                    way_d   = vic_way;
                    cnt_clr = 1'b1;
                    state_d = vic_dirty ? ST_WBACK : ST_FILL;
                end
            end

            ST_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                rd_way  = way_q;
                rd_word = cnt_q;
                if (mem_ack) begin
                    if (cnt_q == LAST_WORD) begin
                        inv_en  = 1'b1;
                        inv_way = way_q;
                        state_d = ST_LOOKUP;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end

            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    dwr_en   = 1'b1;
                    dwr_way  = way_q;
                    dwr_word = cnt_q;
                    dwr_data = mem_rdata;
                    if (cnt_q == LAST_WORD) begin
                        inst_en  = 1'b1;
                        inst_way = way_q;
                        state_d  = ST_LOOKUP;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end

            ST_RESP: begin
                resp_valid = 1'b1;
                state_d    = ST_IDLE;
            end

            default: state_d = ST_IDLE;
        endcase
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12
    AST_RESP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R11
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !resp_valid)); // R11
    AST_DISCARD_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WBACK) |-> (op_q != OP_DISCARD)); // R8
    AST_ZERO_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> (op_q != OP_ZERO)); // R7
    AST_FILL_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && $past(state_q) == ST_WBACK) |-> 1'b0); // R4

endmodule

// File: tb/hint_cache_bench.sv
`timescale 1ns/100ps
module hint_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = 3'd7;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        mem_req, mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    hint_cache u_hint_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int rd_cnt = 0, wr_cnt = 0, pulses = 0, cmd_rd = 0, idle_err = 0;
    bit seen_rd = 0, ord_err = 0, wr_after_rd = 0, busy = 0;
    logic [31:0] mem  [1024];
    logic [31:0] view [1024];

    // Word-addressed memory: one acknowledge per request, one cycle later
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[9:0]] = mem_wdata;
                wr_cnt++;
                if (seen_rd) wr_after_rd = 1;
            end else begin
                mem_rdata <= mem[mem_addr[9:0]];
                if (cmd_rd % 4 != int'(mem_addr[1:0])) ord_err = 1;
                cmd_rd++;
                seen_rd = 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Per-clock monitor
    always @(negedge clk) begin
        if (resp_valid) pulses++;
        if (rst_n && !busy && (mem_req || resp_valid)) idle_err++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: resident lines with age stamps
    typedef struct { int set; int tag; bit dirty; int stamp; } ml_t;
    ml_t mq[$];
    int  tick = 1;

    function automatic int find_line(int s, int t);
        foreach (mq[i]) if (mq[i].set == s && mq[i].tag == t) return i;
        return -1;
    endfunction

    task automatic make_room(input int s, inout int ewr);
        int n = 0, v = -1;
        foreach (mq[i]) if (mq[i].set == s) begin
            n++;
            if (v < 0 || mq[i].stamp < mq[v].stamp) v = i;
        end
        if (n == 2) begin
            if (mq[v].dirty) ewr += 4;
            mq.delete(v);
        end
    endtask

    task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] wd,
                         output int erd, output int ewr, output logic [31:0] ed);
        int s = int'(a[7:4]);
        int t = int'(a[31:8]);
        int w = int'(a[11:2]);
        int b = int'(a[11:4]) * 4;
        int i = find_line(s, t);
        ml_t nl;
        erd = 0; ewr = 0; ed = '0;
        if (op <= 3'd2 || op == 3'd6) begin
            if (i < 0) begin
                make_room(s, ewr);
                nl.set = s; nl.tag = t; nl.dirty = 0; nl.stamp = tick++;
                mq.push_back(nl);
                erd = 4;
                i = find_line(s, t);
            end
            if (op == 3'd6) mq[i].stamp = -(tick++);
            else            mq[i].stamp = tick++;
            if (op == 3'd0 || op == 3'd6) ed = view[w];
            if (op == 3'd1) begin mq[i].dirty = 1; view[w] = wd; end
        end else if (op == 3'd3) begin
            if (i < 0) begin
                make_room(s, ewr);
                nl.set = s; nl.tag = t; nl.dirty = 1; nl.stamp = tick++;
                mq.push_back(nl);
            end else begin
                mq[i].dirty = 1; mq[i].stamp = tick++;
            end
            for (int k = 0; k < 4; k++) view[b+k] = '0;
        end else if (op == 3'd4) begin
            if (i >= 0) begin
                mq.delete(i);
                for (int k = 0; k < 4; k++) view[b+k] = mem[b+k];
            end
        end else if (op == 3'd5) begin
            if (i >= 0) begin
                if (mq[i].dirty) ewr = 4;
                mq.delete(i);
            end
        end
    endtask

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R2";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            3'd5: return "R9";
            3'd6: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [31:0] ad(int t, int s, int w);
        return 32'((t << 8) | (s << 4) | (w << 2));
    endfunction

    task automatic run(input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] wd, input string ovr);
        int erd, ewr, rd0, wr0, p0;
        logic [31:0] ed, got;
        string rq = (ovr != "") ? ovr : req_of(op);
        string rw = (op <= 3'd2 || op == 3'd6) ? "R4" : rq;
        model(op, a, wd, erd, ewr, ed);
        rd0 = rd_cnt; wr0 = wr_cnt; p0 = pulses;
        seen_rd = 0; ord_err = 0; wr_after_rd = 0; cmd_rd = 0;
        @(negedge clk);
        busy = 1;
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid) @(negedge clk);
        got = resp_rdata;
        @(negedge clk);
        busy = 0;
        rd_cnt += cmd_rd;
        chk(got == ed, rq, "response data", got, ed);
        chk(rd_cnt - rd0 == erd, rq, "memory reads", 32'(rd_cnt - rd0), 32'(erd));
        chk(wr_cnt - wr0 == ewr, rw, "memory writes", 32'(wr_cnt - wr0), 32'(ewr));
        chk(pulses - p0 == 1, "R11", "response pulses", 32'(pulses - p0), 32'd1);
        if (erd > 0) chk(!ord_err, "R3", "fill word order", 32'(ord_err), 32'd0);
        if (erd > 0 && ewr > 0)
            chk(!wr_after_rd, "R4", "write-back before fill", 32'(wr_after_rd), 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]  = 32'hA500_0000 ^ (i * 32'h0001_0101);
            view[i] = mem[i];
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);
        chk(resp_valid == 1'b0, "R1", "resp_valid after reset", 32'(resp_valid), 32'd0);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'd0);

        run(3'd0, ad(0,1,2), 0, "R3");            // cold miss
        run(3'd0, ad(0,1,2), 0, "");              // R2 hit
        run(3'd1, ad(0,1,1), 32'h1234, "");
        run(3'd0, ad(0,1,1), 0, "");
        run(3'd1, ad(1,1,0), 32'hBEEF, "R5");     // second way
        run(3'd0, ad(0,1,0), 0, "R5");            // tag 1 becomes LRU
        run(3'd0, ad(2,1,3), 0, "R5");            // dirty LRU victim, R4
        run(3'd0, ad(1,1,0), 0, "R4");            // value survived write-back
        run(3'd2, ad(3,2,0), 0, "");              // R6 prefetch absent
        run(3'd2, ad(3,2,0), 0, "");              // R6 prefetch present
        run(3'd0, ad(3,2,1), 0, "R6");
        run(3'd3, ad(0,3,1), 0, "");              // R7 no read
        run(3'd0, ad(0,3,2), 0, "R7");
        run(3'd5, ad(0,3,0), 0, "R9");            // zero line written back
        run(3'd0, ad(0,3,3), 0, "R7");
        run(3'd1, ad(1,4,0), 32'h55, "");
        run(3'd4, ad(1,4,0), 0, "R8");            // dirty dropped
        run(3'd0, ad(1,4,0), 0, "R8");
        run(3'd4, ad(2,4,0), 0, "R8");            // absent
        run(3'd5, ad(2,4,0), 0, "R9");            // absent
        run(3'd0, ad(0,5,0), 0, "");
        run(3'd5, ad(0,5,0), 0, "R9");            // clean evict
        run(3'd0, ad(0,6,0), 0, "");
        run(3'd0, ad(1,6,0), 0, "");
        run(3'd6, ad(0,6,1), 0, "R10");
        run(3'd0, ad(2,6,0), 0, "R10");           // replaces tag 0
        run(3'd0, ad(1,6,0), 0, "R10");           // still resident
        run(3'd6, ad(3,7,2), 0, "R10");           // load-last miss
        run(3'd7, ad(0,1,0), 0, "R11");

        for (int n = 0; n < 400; n++) begin
            logic [2:0] op = 3'($urandom_range(0, 7));
            run(op, ad($urandom_range(0,3), $urandom_range(8,10), $urandom_range(0,3)),
                $urandom, "");
        end

        chk(idle_err == 0, "R11", "quiet while idle", 32'(idle_err), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule